// File: doc/BRIEF.md
# Delayed-Quotient High-Radix Montgomery Multiplier

This block computes a Montgomery product digit by digit, handling V bits of the multiplier operand X per iteration. Each iteration takes the low V bits of the running accumulator Z as the quotient digit. That digit is not used in the same iteration. It waits in a register and is applied one iteration later. The quotient extraction is therefore off the path from the accumulator register back to itself. The loop body reduces to two V-by-N products merged with the shifted accumulator through a single level of 3:2 carry-save adders.

The caller supplies the modulus in adjusted form, Mt = (k·M + 1) / 2^(2V). Here M is odd, and k is the value below 2^(2V) with k·M ≡ −1 (mod 2^(2V)). The operand length is extended by 2V bits, so the loop runs N/V + 3 iterations. During the loop Z is held in carry-save form. After the loop, a word-serial carry-propagate pass resolves Z, W bits per cycle. The pending quotient digit is then appended below the resolved value to give the result. A one-cycle `done` pulse marks the result as valid.

Top module: `mmq_mont_mul`

## Requirements
- R1: After reset, `done` is low and `z_out` is zero.
- R2: The result follows this recurrence. Z and the held digit Q both start at zero. For i = 0 … N/V+2 (X digits least significant first, zero above bit N−1), capture q = Z mod 2^V, set Z ← ⌊Z/2^V⌋ + Q·Mt + X_i·Y, then set Q ← q.
- R3: The final result is Z·2^V + Q, so `z_out[V-1:0]` equals the last held digit and `z_out >> V` equals the final Z.
- R4: For odd M with Mt formed as above, z_out·2^(N+V) ≡ X·Y (mod M).
- R5: For X, Y < 2^N, the result is below 2^(N+2V+1), so the top bit of `z_out` is zero.
- R6: `done` rises exactly (N/V+3) + ⌈(N+2V+2)/W⌉ clock edges after the edge that samples `start` in idle, and stays high for one cycle only.
- R7: While an operation is in progress, `start` and the operand inputs are ignored. The result and the timing of the running operation are unchanged.
- R8: After `done`, `z_out` holds its value until the next accepted `start`, whatever the operand inputs do.
- R9: No carry is lost. Each carry-save update equals the exact sum ⌊Z/2^V⌋ + products, and the word-serial resolution leaves no carry out of its top word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| x_in | input | N | Multiplier operand X, consumed V bits per iteration |
| y_in | input | N | Multiplicand Y |
| mt_in | input | N | Adjusted modulus Mt = (k·M+1)/2^(2V) |
| z_out | output | N+2V+2 | Result Z·2^V + held quotient digit |
| done | output | 1 | One-cycle pulse: `z_out` valid |

## Verification
The hardest case to reach from the ports is a `start` pulse with fresh operands arriving while an operation is already running. The bench raises `start` a few cycles into the loop phase, with different operands. It then requires both the result and the latency of the first operation to be unchanged. Long carry chains through every resolution word, and a nonzero held digit at the end, only appear with extreme operands. All-ones operands against an all-ones modulus are therefore mixed in with the seeded random cases.

// File: rtl/mmq_pkg.sv
package mmq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_RES  = 2'd2
  } mmq_state_e;
endpackage

// File: rtl/mmq_ctrl.sv
module mmq_ctrl
  import mmq_pkg::*;
#(
  parameter int NI  = 7,
  parameter int NWD = 4,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          load,
  output logic          iter_en,
  output logic          res_en,
  output logic          res_first,
  output logic          res_last,
  output logic          busy,
  output logic [CW-1:0] cnt,
  output logic          done
);
  mmq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_LOOP;
          cnt_d   = '0;
        end
      end
      ST_LOOP: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(NI - 1)) begin
          state_d = ST_RES;
          cnt_d   = '0;
        end
      end
      ST_RES: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(NWD - 1)) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign iter_en   = (state_q == ST_LOOP);
  assign res_en    = (state_q == ST_RES);
  assign res_first = res_en && (cnt_q == '0);
  assign res_last  = res_en && (cnt_q == CW'(NWD - 1));
  assign busy      = (state_q != ST_IDLE);
  assign cnt       = cnt_q;
  assign done      = done_q;

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: the loop phase runs to its end regardless of start
  assert_loop_not_cut_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && cnt_q != CW'(NI - 1)) |=> (state_q == ST_LOOP));
endmodule

// File: rtl/mmq_digit_pe.sv
module mmq_digit_pe #(
  parameter int N  = 32,
  parameter int V  = 8,
  parameter int ZW = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          en,
  input  logic [V-1:0]  x_dig,
  input  logic [N-1:0]  y,
  input  logic [N-1:0]  mt,
  output logic [ZW-1:0] zs_o,
  output logic [ZW-1:0] zc_o,
  output logic [V-1:0]  qold_o
);
  localparam int PW = N + V + 1;

  logic [ZW-1:0] zs_q, zc_q;
  logic [V-1:0]  qold_q;
  logic [V:0]    low_sum;
  logic [V-1:0]  q_now;
  logic          c_low;
  logic [PW-1:0] prod;
  logic [ZW-1:0] opa, opb, opd;
  logic [ZW-1:0] s_vec, m_vec, c_vec;

  // low digit of the redundant accumulator: quotient and carry into the shift
  always_comb begin
    low_sum = {1'b0, zs_q[V-1:0]} + {1'b0, zc_q[V-1:0]};
    q_now   = low_sum[V-1:0];
    c_low   = low_sum[V];
  end

  // merged product array: held quotient times Mt plus digit times Y
  always_comb begin
    prod = PW'(qold_q) * PW'(mt) + PW'(x_dig) * PW'(y);
  end

  always_comb begin
    opa = zs_q >> V;
    opb = zc_q >> V;
    opd = {{(ZW - PW){1'b0}}, prod};
  end

  // one level of 3:2 compression
  genvar k;
  generate
    for (k = 0; k < ZW; k++) begin : g_fa
      assign s_vec[k] = opa[k] ^ opb[k] ^ opd[k];
      assign m_vec[k] = (opa[k] & opb[k]) | (opa[k] & opd[k]) | (opb[k] & opd[k]);
    end
  endgenerate

  assign c_vec = {m_vec[ZW-2:0], c_low};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zs_q   <= '0;
      zc_q   <= '0;
      qold_q <= '0;
    end else if (clear) begin
      zs_q   <= '0;
      zc_q   <= '0;
      qold_q <= '0;
    end else if (en) begin
      zs_q   <= s_vec;
      zc_q   <= c_vec;
      qold_q <= q_now;
    end
  end

  assign zs_o   = zs_q;
  assign zc_o   = zc_q;
  assign qold_o = qold_q;

  // R9: redundant update carries the exact shifted sum plus products
  logic [ZW:0] z_now_val, z_nxt_val, z_ref_val;
  always_comb begin
    z_now_val = {1'b0, zs_q} + {1'b0, zc_q};
    z_ref_val = (z_now_val >> V) + (ZW + 1)'(prod);
    z_nxt_val = {1'b0, s_vec} + {1'b0, c_vec};
  end

  assert_csa_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (z_nxt_val == z_ref_val));
endmodule

// File: rtl/mmq_word_cpa.sv
module mmq_word_cpa #(
  parameter int W   = 16,
  parameter int NWD = 4,
  parameter int CW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             first,
  input  logic             last,
  input  logic [CW-1:0]    idx,
  input  logic [NWD*W-1:0] zs,
  input  logic [NWD*W-1:0] zc,
  output logic [NWD*W-1:0] res_o
);
  localparam int ZP = NWD * W;

  logic [W-1:0]  wa, wb, wsum;
  logic          cin, cout, cy_q;
  logic [ZP-1:0] res_q, res_d;

  always_comb begin
    wa = '0;
    wb = '0;
    for (int k = 0; k < NWD; k++) begin
      if (idx == CW'(k)) begin
        wa = zs[k*W +: W];
        wb = zc[k*W +: W];
      end
    end
    cin          = first ? 1'b0 : cy_q;
    {cout, wsum} = {1'b0, wa} + {1'b0, wb} + {{W{1'b0}}, cin};
  end

  generate
    if (NWD > 1) begin : g_multi
      assign res_d = {wsum, res_q[ZP-1:W]};
    end else begin : g_single
      assign res_d = wsum;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q  <= 1'b0;
      res_q <= '0;
    end else if (en) begin
      cy_q  <= cout;
      res_q <= res_d;
    end
  end

  assign res_o = res_q;

  // R9: resolution never overflows the top word
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && last) |-> !cout);
endmodule

// File: rtl/mmq_mont_mul.sv
module mmq_mont_mul #(
  parameter int N = 32,
  parameter int V = 8,
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N-1:0]         x_in,
  input  logic [N-1:0]         y_in,
  input  logic [N-1:0]         mt_in,
  output logic [N+2*V+1:0]     z_out,
  output logic                 done
);
  localparam int ZW  = N + 2 * V + 2;
  localparam int RW  = N + 2 * V + 2;
  localparam int NI  = N / V + 3;
  localparam int NWD = (ZW + W - 1) / W;
  localparam int ZP  = NWD * W;
  localparam int CW  = $clog2(NI + NWD + 1);

  logic          load, iter_en, res_en, res_first, res_last, busy;
  logic [CW-1:0] cnt;
  logic [N-1:0]  x_q, y_q, mt_q;
  logic [N-1:0]  x_d, y_d, mt_d;
  logic [ZW-1:0] zs, zc;
  logic [ZP-1:0] zs_p, zc_p, res;
  logic [V-1:0]  qold;

  mmq_ctrl #(.NI(NI), .NWD(NWD), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load     (load),
    .iter_en  (iter_en),
    .res_en   (res_en),
    .res_first(res_first),
    .res_last (res_last),
    .busy     (busy),
    .cnt      (cnt),
    .done     (done)
  );

  // operand registers: next-state then storage
  always_comb begin
    x_d  = x_q;
    y_d  = y_q;
    mt_d = mt_q;
    if (load) begin
      x_d  = x_in;
      y_d  = y_in;
      mt_d = mt_in;
    end else if (iter_en) begin
      x_d = x_q >> V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      mt_q <= '0;
    end else if (load || iter_en) begin
      x_q  <= x_d;
      y_q  <= y_d;
      mt_q <= mt_d;
    end
  end

  mmq_digit_pe #(.N(N), .V(V), .ZW(ZW)) u_pe (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .en    (iter_en),
    .x_dig (x_q[V-1:0]),
    .y     (y_q),
    .mt    (mt_q),
    .zs_o  (zs),
    .zc_o  (zc),
    .qold_o(qold)
  );

  generate
    if (ZP > ZW) begin : g_pad
      assign zs_p = {{(ZP - ZW){1'b0}}, zs};
      assign zc_p = {{(ZP - ZW){1'b0}}, zc};
    end else begin : g_nopad
      assign zs_p = zs;
      assign zc_p = zc;
    end
  endgenerate

  mmq_word_cpa #(.W(W), .NWD(NWD), .CW(CW)) u_cpa (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (res_en),
    .first(res_first),
    .last (res_last),
    .idx  (cnt),
    .zs   (zs_p),
    .zc   (zc_p),
    .res_o(res)
  );

  // shift the resolved accumulator up one digit and insert the held quotient
  assign z_out = {res[RW-V-1:0], qold};

  // R7: operands captured at start stay frozen for the whole operation
  assert_ops_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(y_q) && $stable(mt_q)));

  // R8: result stays put while idle and no start is taken
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(load)) |-> $stable(z_out));
endmodule

// File: tb/sim_mmq_mont_mul.sv
module sim_mmq_mont_mul;
  localparam int N   = 32;
  localparam int V   = 8;
  localparam int W   = 16;
  localparam int ZW  = N + 2 * V + 2;
  localparam int RW  = N + 2 * V + 2;
  localparam int NI  = N / V + 3;
  localparam int NWD = (ZW + W - 1) / W;
  localparam int LAT = NI + NWD;
  localparam int BW  = 2 * RW + N + 2 * V;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  x_in = '0, y_in = '0, mt_in = '0;
  logic [RW-1:0] z_out;
  logic          done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mmq_mont_mul #(.N(N), .V(V), .W(W)) u0 (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .x_in (x_in),
    .y_in (y_in),
    .mt_in(mt_in),
    .z_out(z_out),
    .done (done)
  );

  task automatic chk(input bit ok, input string req, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] calc_mt(input logic [BW-1:0] m);
    logic [BW-1:0] msk, inv, kk;
    msk = (BW'(1) << (2 * V)) - 1;
    inv = m & msk;
    for (int r = 0; r < 8; r++) inv = (inv * (BW'(2) - m * inv)) & msk;
    kk = ((msk + 1) - inv) & msk;
    return (kk * m + 1) >> (2 * V);
  endfunction

  task automatic model(input logic [BW-1:0] x, input logic [BW-1:0] y,
                       input logic [BW-1:0] mt, output logic [BW-1:0] zf,
                       output logic [BW-1:0] qf);
    logic [BW-1:0] z, qo, q, xd, dm;
    dm = (BW'(1) << V) - 1;
    z  = '0;
    qo = '0;
    for (int i = 0; i < NI; i++) begin
      xd = (x >> (i * V)) & dm;
      q  = z & dm;
      z  = (z >> V) + qo * mt + xd * y;
      qo = q;
    end
    zf = z;
    qf = qo;
  endtask

  // one operation; if interrupt set, a second start with other operands comes mid-run
  task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y,
                        input logic [N-1:0] m, input bit interrupt);
    logic [BW-1:0] mt, zf, qf, full, act;
    int lat;
    mt = calc_mt(BW'(m));
    model(BW'(x), BW'(y), mt, zf, qf);
    full = (zf << V) + qf;
    @(negedge clk);
    x_in  = x;
    y_in  = y;
    mt_in = mt[N-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    chk(done == 1'b0, "R6 done low right after start", BW'(done), 0);
    while (!done && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
      if (interrupt && lat == 3) begin
        x_in  = ~x;
        y_in  = ~y;
        mt_in = ~mt[N-1:0];
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    chk(lat == LAT, interrupt ? "R7 latency with start while busy" : "R6 latency",
        BW'(lat), BW'(LAT));
    act = BW'(z_out);
    chk(act == full, interrupt ? "R7 result with start while busy" : "R2 result",
        act, full);
    chk(BW'(z_out[V-1:0]) == qf, "R3 held digit inserted", BW'(z_out[V-1:0]), qf);
    chk(BW'(z_out >> V) == zf, "R3 shifted accumulator", BW'(z_out >> V), zf);
    if (m > 1) begin
      chk(((act << (N + V)) % BW'(m)) == ((BW'(x) * BW'(y)) % BW'(m)), "R4 congruence",
          (act << (N + V)) % BW'(m), (BW'(x) * BW'(y)) % BW'(m));
    end
    chk(z_out[RW-1] == 1'b0, "R5 result bound", BW'(z_out), full);
    // R8: change inputs without start; result must hold
    x_in  = ~x_in;
    y_in  = ~y_in;
    mt_in = ~mt_in;
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle only", BW'(done), 0);
    @(negedge clk);
    @(negedge clk);
    chk(BW'(z_out) == full, "R8 result held", BW'(z_out), full);
  endtask

  function automatic logic [N-1:0] rnd_n();
    logic [N-1:0] r;
    r = '0;
    for (int k = 0; k < N; k += 32) r = (r << 32) | N'($urandom());
    return r;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1 done after reset", BW'(done), 0);
    chk(z_out == '0, "R1 z_out after reset", BW'(z_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(z_out == '0 && done == 1'b0, "R1 outputs idle after release", BW'(z_out), 0);

    // directed corners
    run_op('0, rnd_n(), rnd_n() | 1, 1'b0);                 // R2 zero multiplier
    run_op(rnd_n(), '0, rnd_n() | 1, 1'b0);                 // R2 zero multiplicand
    run_op('1, '1, '1, 1'b0);                               // R9 long carries, all ones
    run_op('1, '1, N'(1), 1'b0);                            // R4 trivial modulus
    run_op('1, 1, (N'(1) << (N - 1)) | 1, 1'b0);            // R5 small modulus extreme
    run_op(rnd_n(), rnd_n(), rnd_n() | 1, 1'b1);            // R7 start while busy
    run_op('1, '1, '1, 1'b1);                               // R7 with extreme values

    // seeded random
    for (int t = 0; t < 40; t++) begin
      run_op(rnd_n(), rnd_n(), rnd_n() | 1, (t % 7) == 3);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule